// File: doc/BRIEF.md
# Calendar alarm matcher with don't-care fields

This block decides when a real-time clock's alarm fires. It watches five live BCD clock fields: seconds, minutes, hours, day of month and month. On every 10 ms time-update strobe it compares them with five preset alarm fields. A preset field that holds all ones (FFh) takes no part in the comparison. This lets software build repeating alarms, for example every minute at second 05, or every hour at 12:05.

When the alarm is enabled and every compared field agrees, a sticky alarm flag is raised. The flag drives an interrupt request whenever the mask input allows it. The flag is raised only on the update where the agreement begins. A clock that stays equal for many updates therefore raises it once, and a software clear inside that window stays cleared. Standby does not suppress the alarm interrupt. Software clear strobes are not honoured during standby, because no host can issue a genuine clear there.

Top module: `alarm_match_unit`

## Requirements
- R1: After reset `flag_o` and `irq_o` are 0.
- R2: Suppose `tick_i` and `en_i` are high, every alarm field that is not FFh equals its clock field, and the previous `tick_i` with `en_i` high did not see such a match. Then `flag_o` is 1 from the next clock cycle on.
- R3: An alarm field equal to FFh counts as matching any clock value. Field k sits at bits [8k+7:8k] of both field buses: 0 seconds, 1 minutes, 2 hours, 3 day, 4 month.
- R4: While `en_i` is low, a strobe never sets the flag, and the match history is cleared.
- R5: Without a `tick_i` pulse the flag is never set, whatever the field values.
- R6: A match that persists across consecutive strobes sets the flag only on its first strobe. After a clear, the flag sets again only after a strobe without a match.
- R7: Once set, `flag_o` stays 1 until `flag_clr_i` is high while `standby_i` is low. It is then 0 from the next cycle.
- R8: A clear and a new match in the same cycle leave the flag set.
- R9: `irq_o` is 1 exactly when `flag_o` and `mask_i` are both 1, including during standby.
- R10: While `standby_i` is high, `flag_clr_i` has no effect on the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | 10 ms time-update strobe, one cycle |
| en_i | input | 1 | Alarm enable |
| mask_i | input | 1 | Interrupt mask, 1 lets the flag drive `irq_o` |
| flag_clr_i | input | 1 | Software flag-clear strobe |
| standby_i | input | 1 | Standby indication |
| now_i | input | 40 | Live BCD clock fields, five bytes |
| alm_i | input | 40 | Preset alarm fields, five bytes |
| flag_o | output | 1 | Sticky alarm flag |
| irq_o | output | 1 | Alarm interrupt request |

## Verification
The bench sweeps all 32 combinations of don't-care fields. For each combination it tries a clock that agrees fully and five clocks that each differ in exactly one field. This separates a broken per-field comparator, a wrong field position and wildcard handling from one another. Directed sequences then cover the edge behaviour: a persistent match after a clear, a mismatch followed by a match, and a clear colliding with a fresh match. They also check clears issued during standby, and interrupt gating with mask and standby combined.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
  localparam int unsigned ALM_FIELDS  = 5;
  localparam int unsigned ALM_FIELD_W = 8;

  typedef enum logic [1:0] {
    FLG_HOLD = 2'b00,
    FLG_SET  = 2'b01,
    FLG_CLR  = 2'b10
  } flag_op_e;
endpackage

// File: rtl/alarm_field_cmp.sv
module alarm_field_cmp #(
  parameter int unsigned FIELD_W = 8
) (
  input  logic [FIELD_W-1:0] alm_i,
  input  logic [FIELD_W-1:0] now_i,
  output logic               hit_o
);
  localparam logic [FIELD_W-1:0] WILDCARD = {FIELD_W{1'b1}};

  always_comb hit_o = (alm_i == WILDCARD) || (alm_i == now_i);
endmodule

// File: rtl/alarm_edge_det.sv
module alarm_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic en_i,
  input  logic match_i,
  output logic first_o
);
  logic seen_q;

  // history only advances on update strobes
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     seen_q <= 1'b0;
    else if (tick_i) seen_q <= en_i & match_i;
  end

  always_comb first_o = tick_i & en_i & match_i & ~seen_q;
endmodule

// File: rtl/alarm_flag_ctrl.sv
module alarm_flag_ctrl
  import alarm_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic standby_i,
  output logic flag_o
);
  flag_op_e op;
  logic     flag_q;

  always_comb begin
    op = FLG_HOLD;
    if (set_i)                   op = FLG_SET;  // set beats clear
    else if (clr_i && !standby_i) op = FLG_CLR;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= 1'b0;
    else begin
      unique case (op)
        FLG_SET:  flag_q <= 1'b1;
        FLG_CLR:  flag_q <= 1'b0;
        default:  flag_q <= flag_q;
      endcase
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/alarm_match_unit.sv
module alarm_match_unit
  import alarm_pkg::*;
#(
  parameter int unsigned NUM_FIELDS = ALM_FIELDS,
  parameter int unsigned FIELD_W    = ALM_FIELD_W,
  localparam int unsigned BUS_W     = NUM_FIELDS * FIELD_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             en_i,
  input  logic             mask_i,
  input  logic             flag_clr_i,
  input  logic             standby_i,
  input  logic [BUS_W-1:0] now_i,
  input  logic [BUS_W-1:0] alm_i,
  output logic             flag_o,
  output logic             irq_o
);
  logic [NUM_FIELDS-1:0] field_hit;
  logic                  match_all;
  logic                  first_hit;

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_cmp
    alarm_field_cmp #(.FIELD_W(FIELD_W)) u_cmp (
      .alm_i (alm_i[g*FIELD_W +: FIELD_W]),
      .now_i (now_i[g*FIELD_W +: FIELD_W]),
      .hit_o (field_hit[g])
    );
  end

  always_comb match_all = &field_hit;

  alarm_edge_det u_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_i),
    .en_i    (en_i),
    .match_i (match_all),
    .first_o (first_hit)
  );

  alarm_flag_ctrl u_flag (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (first_hit),
    .clr_i     (flag_clr_i),
    .standby_i (standby_i),
    .flag_o    (flag_o)
  );

  // standby does not gate the alarm request
  always_comb irq_o = flag_o & mask_i;
endmodule

// File: rtl/alarm_match_chk.sv
module alarm_match_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic tick_i,
  input logic en_i,
  input logic mask_i,
  input logic flag_clr_i,
  input logic standby_i,
  input logic flag_o,
  input logic irq_o
);
  AST_ROSE_NEEDS_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_o) |-> $past(tick_i)); // R5
  AST_ROSE_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_o) |-> $past(en_i)); // R4
  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !flag_clr_i) |=> flag_o); // R7
  AST_FLAG_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_clr_i && !standby_i && !tick_i) |=> !flag_o); // R7
  AST_STBY_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && standby_i) |=> flag_o); // R10
  AST_IRQ_IN_STBY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (standby_i && flag_o && mask_i) |-> irq_o); // R9
  AST_IRQ_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mask_i |-> !irq_o); // R9
endmodule

bind alarm_match_unit alarm_match_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tick_i     (tick_i),
  .en_i       (en_i),
  .mask_i     (mask_i),
  .flag_clr_i (flag_clr_i),
  .standby_i  (standby_i),
  .flag_o     (flag_o),
  .irq_o      (irq_o)
);

// File: tb/alarm_match_unit_tb.sv
`timescale 1ns/1ps
module alarm_match_unit_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0, en_i = 1'b0, mask_i = 1'b0;
  logic        flag_clr_i = 1'b0, standby_i = 1'b0;
  logic [39:0] now_i = '0, alm_i = '0;
  logic        flag_o, irq_o;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  localparam logic [39:0] BASE = {8'h03, 8'h21, 8'h07, 8'h12, 8'h05};

  always #10 clk_i = ~clk_i;

  alarm_match_unit u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .en_i(en_i),
    .mask_i(mask_i), .flag_clr_i(flag_clr_i), .standby_i(standby_i),
    .now_i(now_i), .alm_i(alm_i), .flag_o(flag_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic tick();
    tick_i = 1'b1;
    @(negedge clk_i);
    tick_i = 1'b0;
  endtask

  task automatic clear();
    flag_clr_i = 1'b1;
    @(negedge clk_i);
    flag_clr_i = 1'b0;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout expected finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk_i);
    @(negedge clk_i);
    chk("R1 flag", flag_o, 1'b0);
    chk("R1 irq", irq_o, 1'b0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // sweep wildcard masks x single-field mismatch
    for (int m = 0; m < 32; m++) begin
      for (int d = -1; d < 5; d++) begin
        logic [39:0] a, n;
        logic exp;
        a = BASE;
        for (int k = 0; k < 5; k++) if (m[k]) a[k*8 +: 8] = 8'hFF;
        n = BASE;
        if (d >= 0) n[d*8 +: 8] = BASE[d*8 +: 8] + 8'h01;
        exp = (d < 0) || m[d];
        alm_i = a; now_i = n;
        en_i = 1'b0; tick();
        clear();
        en_i = 1'b1; tick();
        chk(m != 0 ? "R3 wildcard sweep" : "R2 exact sweep", flag_o, exp);
      end
    end

    // state: exact alarm matching, flag 1, history 1
    alm_i = BASE; now_i = BASE;
    en_i = 1'b0; tick(); clear();
    en_i = 1'b1; tick();
    chk("R2 first match", flag_o, 1'b1);
    for (int i = 0; i < 20; i++) @(negedge clk_i);
    chk("R7 sticky", flag_o, 1'b1);
    clear();
    chk("R7 cleared", flag_o, 1'b0);
    tick();
    chk("R6 persisting match no re-set", flag_o, 1'b0);
    now_i = BASE + 40'd1; tick();
    chk("R6 mismatch tick", flag_o, 1'b0);
    now_i = BASE; tick();
    chk("R6 re-armed match", flag_o, 1'b1);

    // R8: clear collides with fresh match
    clear();
    now_i = BASE + 40'd1; tick();
    now_i = BASE;
    flag_clr_i = 1'b1; tick_i = 1'b1;
    @(negedge clk_i);
    flag_clr_i = 1'b0; tick_i = 1'b0;
    chk("R8 set wins", flag_o, 1'b1);

    // R9 / R10
    mask_i = 1'b0; @(negedge clk_i);
    chk("R9 masked", irq_o, 1'b0);
    mask_i = 1'b1; @(negedge clk_i);
    chk("R9 unmasked", irq_o, 1'b1);
    standby_i = 1'b1;
    clear();
    chk("R10 clear ignored in standby", flag_o, 1'b1);
    chk("R9 irq in standby", irq_o, 1'b1);
    mask_i = 1'b0; @(negedge clk_i);
    chk("R9 masked in standby", irq_o, 1'b0);
    standby_i = 1'b0;
    clear();
    chk("R7 clear after standby", flag_o, 1'b0);
    chk("R9 irq follows flag", irq_o, 1'b0);

    // R4 / R5
    en_i = 1'b0; tick();
    chk("R4 disabled tick", flag_o, 1'b0);
    en_i = 1'b1;
    for (int i = 0; i < 10; i++) @(negedge clk_i);
    chk("R5 no tick no set", flag_o, 1'b0);
    tick();
    chk("R4 history cleared by disable", flag_o, 1'b1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule